// File: doc/BRIEF.md
# Segment and Page Address Translation Front End

This block sits between a processor's load/store/fetch logic and its translation lookaside buffers. It accepts a 32-bit virtual address and an access kind, and chooses one of three ways to produce a physical address. When translation is switched off globally, the address passes straight through. When the address's top nibble names a segment that the segment map marks as direct-mapped, the top nibble is replaced by a 4-bit base held for that segment. In every other case, the block sends the virtual page number to an instruction TLB or a data TLB and builds the physical address from the frame number that comes back.

Requests use a valid/ready handshake and are handled one at a time. A bypassed or segment-mapped request answers one cycle after it is accepted. A page-mapped request waits for the TLB's answer and then responds one cycle later. Configuration inputs are sampled in the cycle the request is accepted.

Top module: `segx_top`

## Requirements
- R1: Translation is on when global config bit 2 or bit 3 is 1. When it is off, the response has path code 0 (bypass) and physical address equal to the virtual address, whatever the segment map holds.
- R2: When translation is on, the segment is vaddr[31:28]. If seg_map bit (segment) is 1, the response has path code 1 (segment).
- R3: Segments 0 to 7 take their base nibble from seg_base_lo, and segments 8 to 15 take it from seg_base_hi. The nibble used is bits [4*(segment mod 8)+3 : 4*(segment mod 8)].
- R4: A segment-mapped physical address is {base nibble, vaddr[27:0]}.
- R5: A bypassed or segment-mapped response reports perm = 3'b111 (bit 2 read, bit 1 write, bit 0 execute) and miss = 0, for any access kind. rsp_valid is high for exactly the one cycle after acceptance.
- R6: Otherwise the request is page-mapped. Access kind 2 (execute) raises itlb_req_valid. Kinds 0 (read), 1 (write) and 3 raise dtlb_req_valid. Only one of the two is ever high. tlb_vpn = vaddr[31:13], and the request is held until tlb_rsp_valid.
- R7: One cycle after tlb_rsp_valid, the block responds with path code 2 (page), physical address tlb_rsp_pfn shifted left by 13 (low 13 bits zero), and the TLB's miss and perm values.
- R8: req_ready is low from acceptance until the response cycle has passed. A req_valid raised while req_ready is low is ignored and produces neither a response nor a TLB request.
- R9: After reset, req_ready is 1 and rsp_valid, itlb_req_valid and dtlb_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 treated as data |
| glob_cfg | input | 32 | Global config; bit 2 or bit 3 turns translation on |
| seg_map | input | 16 | One direct-map bit per segment |
| seg_base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| seg_base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| itlb_req_valid | output | 1 | Lookup request to the instruction TLB |
| dtlb_req_valid | output | 1 | Lookup request to the data TLB |
| tlb_vpn | output | 19 | Virtual page number for the lookup |
| tlb_rsp_valid | input | 1 | TLB answer present |
| tlb_rsp_miss | input | 1 | TLB reports a fault |
| tlb_rsp_pfn | input | 19 | Frame number returned by the TLB |
| tlb_rsp_perm | input | 3 | Permissions from the TLB (read, write, execute) |
| rsp_valid | output | 1 | Translation result present |
| rsp_path | output | 2 | 0 bypass, 1 segment, 2 page |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permissions (read, write, execute) |
| rsp_miss | output | 1 | Fault indication |

## Verification
The assertions assume the TLB raises tlb_rsp_valid only while a lookup is pending. They also assume the TLB answers each lookup once. The stimulus raises tlb_rsp_valid for a single cycle, and only after it has seen itlb_req_valid or dtlb_req_valid high at a falling edge. New requests are offered only while req_ready is high. The single exception is the test for R8, which raises req_valid during a pending lookup on purpose and drops it before the block returns to idle.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int ADDR_W     = 32;
    localparam int CFG_W      = 32;
    localparam int SEG_W      = 4;
    localparam int PAGE_SHIFT = 13;
    localparam int VPN_W      = ADDR_W - PAGE_SHIFT;
    localparam int NSEG       = 1 << SEG_W;

    // Global config bits that switch translation on.
    localparam logic [CFG_W-1:0] MMU_ON_MASK = 32'h0000_000C;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PATH_BYPASS  = 2'd0,
        PATH_SEGMENT = 2'd1,
        PATH_PAGE    = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    localparam perm_t PERM_ALL = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};

    function automatic logic mmu_enabled(input logic [CFG_W-1:0] gcfg);
        return |(gcfg & MMU_ON_MASK);
    endfunction

    function automatic logic goes_to_itlb(input acc_kind_e kind);
        return kind == ACC_EXEC;
    endfunction

endpackage

// File: rtl/segx_decode.sv
module segx_decode
    import segx_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int SW  = SEG_W,
    parameter int CW  = CFG_W
) (
    input  logic [AW-1:0]        vaddr,
    input  logic [CFG_W-1:0]     gcfg,
    input  logic [(1<<SW)-1:0]   seg_map,
    input  logic [CW-1:0]        base_lo,
    input  logic [CW-1:0]        base_hi,
    output path_e                path,
    output logic [AW-1:0]        direct_paddr
);
    localparam int NS      = 1 << SW;
    localparam int PER_REG = CW / SW;
    localparam int OFFS_W  = AW - SW;

    logic [SW-1:0] seg_base [NS];
    logic [SW-1:0] seg;
    logic          on;

    // One base nibble per segment: low register first, then high.
    for (genvar s = 0; s < NS; s++) begin : g_seg
        if (s < PER_REG) begin : g_lo
            assign seg_base[s] = base_lo[(s % PER_REG)*SW +: SW];
        end else begin : g_hi
            assign seg_base[s] = base_hi[(s % PER_REG)*SW +: SW];
        end
    end

    assign seg = vaddr[AW-1 -: SW];
    assign on  = mmu_enabled(gcfg);

    always_comb begin
        if (!on) begin
            path         = PATH_BYPASS;
            direct_paddr = vaddr;
        end else begin
            path         = seg_map[seg] ? PATH_SEGMENT : PATH_PAGE;
            direct_paddr = {seg_base[seg], vaddr[OFFS_W-1:0]};
        end
    end

endmodule

// File: rtl/segx_steer.sv
module segx_steer
    import segx_pkg::*;
(
    input  logic      active,
    input  acc_kind_e kind,
    output logic      itlb_req,
    output logic      dtlb_req
);
    assign itlb_req = active &&  goes_to_itlb(kind);
    assign dtlb_req = active && !goes_to_itlb(kind);
endmodule

// File: rtl/segx_ctrl.sv
module segx_ctrl
    import segx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PS = PAGE_SHIFT,
    localparam int VW = AW - PS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  acc_kind_e     req_kind,
    input  logic [VW-1:0] req_vpn,
    input  path_e         dec_path,
    input  logic [AW-1:0] dec_paddr,
    output logic          tlb_active,
    output acc_kind_e     tlb_kind,
    output logic [VW-1:0] tlb_vpn,
    input  logic          tlb_rsp_valid,
    input  logic          tlb_rsp_miss,
    input  logic [VW-1:0] tlb_rsp_pfn,
    input  perm_t         tlb_rsp_perm,
    output logic          rsp_valid,
    output path_e         rsp_path,
    output logic [AW-1:0] rsp_paddr,
    output perm_t         rsp_perm,
    output logic          rsp_miss
);
    ctl_state_e state;
    logic       accept;

    assign accept     = req_valid && (state == ST_IDLE);
    assign req_ready  = (state == ST_IDLE);
    assign tlb_active = (state == ST_WAIT);
    assign rsp_valid  = (state == ST_RESP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tlb_kind  <= ACC_READ;
            tlb_vpn   <= '0;
            rsp_path  <= PATH_BYPASS;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
            rsp_miss  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    if (dec_path == PATH_PAGE) begin
                        state    <= ST_WAIT;
                        tlb_kind <= req_kind;
                        tlb_vpn  <= req_vpn;
                    end else begin
                        state     <= ST_RESP;
                        rsp_path  <= dec_path;
                        rsp_paddr <= dec_paddr;
                        rsp_perm  <= PERM_ALL;
                        rsp_miss  <= 1'b0;
                    end
                end
                ST_WAIT: if (tlb_rsp_valid) begin
                    state     <= ST_RESP;
                    rsp_path  <= PATH_PAGE;
                    rsp_paddr <= {tlb_rsp_pfn, {PS{1'b0}}};
                    rsp_perm  <= tlb_rsp_perm;
                    rsp_miss  <= tlb_rsp_miss;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_fast_resp_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_path != PATH_PAGE) |=> rsp_valid);

    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_fast_perm_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_path != PATH_PAGE) |-> (rsp_perm == PERM_ALL && !rsp_miss));

    p_page_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_path == PATH_PAGE) |-> (rsp_paddr[PS-1:0] == '0));

    p_tlb_answer_r7: assert property (@(posedge clk) disable iff (rst)
        (tlb_active && tlb_rsp_valid) |=> (rsp_valid && rsp_path == PATH_PAGE));

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (tlb_active || rsp_valid) |-> !req_ready);

endmodule

// File: rtl/segx_top.sv
module segx_top
    import segx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic [31:0] glob_cfg,
    input  logic [15:0] seg_map,
    input  logic [31:0] seg_base_lo,
    input  logic [31:0] seg_base_hi,
    output logic        itlb_req_valid,
    output logic        dtlb_req_valid,
    output logic [18:0] tlb_vpn,
    input  logic        tlb_rsp_valid,
    input  logic        tlb_rsp_miss,
    input  logic [18:0] tlb_rsp_pfn,
    input  logic [2:0]  tlb_rsp_perm,
    output logic        rsp_valid,
    output logic [1:0]  rsp_path,
    output logic [31:0] rsp_paddr,
    output logic [2:0]  rsp_perm,
    output logic        rsp_miss
);
    path_e           dec_path;
    logic [31:0]     dec_paddr;
    logic            tlb_active;
    acc_kind_e       tlb_kind;
    path_e           rsp_path_e;
    perm_t           rsp_perm_s;

    segx_decode #(.AW(ADDR_W), .SW(SEG_W), .CW(CFG_W)) u_decode (
        .vaddr        (req_vaddr),
        .gcfg         (glob_cfg),
        .seg_map      (seg_map),
        .base_lo      (seg_base_lo),
        .base_hi      (seg_base_hi),
        .path         (dec_path),
        .direct_paddr (dec_paddr)
    );

    segx_ctrl #(.AW(ADDR_W), .PS(PAGE_SHIFT)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_kind      (acc_kind_e'(req_kind)),
        .req_vpn       (req_vaddr[ADDR_W-1:PAGE_SHIFT]),
        .dec_path      (dec_path),
        .dec_paddr     (dec_paddr),
        .tlb_active    (tlb_active),
        .tlb_kind      (tlb_kind),
        .tlb_vpn       (tlb_vpn),
        .tlb_rsp_valid (tlb_rsp_valid),
        .tlb_rsp_miss  (tlb_rsp_miss),
        .tlb_rsp_pfn   (tlb_rsp_pfn),
        .tlb_rsp_perm  (perm_t'(tlb_rsp_perm)),
        .rsp_valid     (rsp_valid),
        .rsp_path      (rsp_path_e),
        .rsp_paddr     (rsp_paddr),
        .rsp_perm      (rsp_perm_s),
        .rsp_miss      (rsp_miss)
    );

    segx_steer u_steer (
        .active   (tlb_active),
        .kind     (tlb_kind),
        .itlb_req (itlb_req_valid),
        .dtlb_req (dtlb_req_valid)
    );

    assign rsp_path = rsp_path_e;
    assign rsp_perm = rsp_perm_s;

    p_one_tlb_r6: assert property (@(posedge clk) disable iff (rst)
        !(itlb_req_valid && dtlb_req_valid));

    p_exec_to_itlb_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && dec_path == PATH_PAGE && req_kind == 2'd2)
        |=> (itlb_req_valid && !dtlb_req_valid));

    p_hold_lookup_r6: assert property (@(posedge clk) disable iff (rst)
        ((itlb_req_valid || dtlb_req_valid) && !tlb_rsp_valid)
        |=> ((itlb_req_valid || dtlb_req_valid) && $stable(tlb_vpn)));

endmodule

// File: tb/sim_segx_top.sv
module sim_segx_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] glob_cfg = '0;
    logic [15:0] seg_map = '0;
    logic [31:0] seg_base_lo = 32'h8765_4321;
    logic [31:0] seg_base_hi = 32'h0FED_CBA9;
    logic        itlb_req_valid, dtlb_req_valid;
    logic [18:0] tlb_vpn;
    logic        tlb_rsp_valid = 1'b0;
    logic        tlb_rsp_miss = 1'b0;
    logic [18:0] tlb_rsp_pfn = '0;
    logic [2:0]  tlb_rsp_perm = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_path;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic        rsp_miss;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    segx_top u0 (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    // Bypass or segment request: response one cycle after acceptance.
    task automatic fast_req(input logic [31:0] va, input logic [1:0] kind,
                            input logic [1:0] exp_path, input logic [31:0] exp_pa, input string req);
        @(negedge clk);
        ck({req, " ready"}, {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        ck({req, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        ck({req, " path"}, {30'b0, rsp_path}, {30'b0, exp_path});
        ck({req, " paddr"}, rsp_paddr, exp_pa);
        ck("R5 perm", {29'b0, rsp_perm}, 32'd7);
        ck("R5 miss", {31'b0, rsp_miss}, 32'd0);
        ck("R8 not ready in response", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        ck("R5 single-cycle response", {31'b0, rsp_valid}, 32'd0);
        ck("R6 no lookup on fast path", {30'b0, itlb_req_valid, dtlb_req_valid}, 32'd0);
    endtask

    // Page request with a TLB model answering after 'lat' waiting cycles.
    task automatic page_req(input logic [31:0] va, input logic [1:0] kind,
                            input logic [18:0] pfn, input logic [2:0] perm, input logic miss,
                            input int lat, input bit poke_busy);
        bit exp_i;
        exp_i = (kind == 2'd2);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        ck("R6 itlb request", {31'b0, itlb_req_valid}, {31'b0, exp_i});
        ck("R6 dtlb request", {31'b0, dtlb_req_valid}, {31'b0, !exp_i});
        ck("R6 vpn", {13'b0, tlb_vpn}, {13'b0, va[31:13]});
        ck("R8 busy not ready", {31'b0, req_ready}, 32'd0);
        ck("R7 no early response", {31'b0, rsp_valid}, 32'd0);
        for (int i = 0; i < lat; i++) begin
            if (poke_busy) begin
                req_valid = 1'b1; req_vaddr = 32'h0000_0000; req_kind = 2'd0;
            end
            @(negedge clk);
            ck("R6 lookup held", {31'b0, itlb_req_valid | dtlb_req_valid}, 32'd1);
            ck("R6 vpn held", {13'b0, tlb_vpn}, {13'b0, va[31:13]});
        end
        req_valid = 1'b0;
        tlb_rsp_valid = 1'b1; tlb_rsp_pfn = pfn; tlb_rsp_perm = perm; tlb_rsp_miss = miss;
        @(negedge clk);
        tlb_rsp_valid = 1'b0;
        ck("R7 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        ck("R7 path page", {30'b0, rsp_path}, 32'd2);
        ck("R7 paddr", rsp_paddr, {pfn, 13'b0});
        ck("R7 perm", {29'b0, rsp_perm}, {29'b0, perm});
        ck("R7 miss", {31'b0, rsp_miss}, {31'b0, miss});
        ck("R6 lookup dropped", {30'b0, itlb_req_valid, dtlb_req_valid}, 32'd0);
        @(negedge clk);
        ck("R8 no extra response", {31'b0, rsp_valid}, 32'd0);
        ck("R8 no extra lookup", {30'b0, itlb_req_valid, dtlb_req_valid}, 32'd0);
        ck("R8 ready again", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ck("R9 ready", {31'b0, req_ready}, 32'd1);
        ck("R9 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        ck("R9 tlb requests", {30'b0, itlb_req_valid, dtlb_req_valid}, 32'd0);
    endtask

    task automatic t_bypass;
        glob_cfg = 32'h0000_0000; seg_map = 16'hFFFF;
        fast_req(32'hDEAD_BEEF, 2'd0, 2'd0, 32'hDEAD_BEEF, "R1 off");
        glob_cfg = 32'hFFFF_FFF3;
        fast_req(32'h3000_4123, 2'd2, 2'd0, 32'h3000_4123, "R1 other bits");
    endtask

    task automatic t_segment;
        seg_map = 16'h8181;
        glob_cfg = 32'h0000_0004;
        fast_req(32'h0123_4567, 2'd0, 2'd1, 32'h1123_4567, "R3 R4 seg0");
        fast_req(32'h7ABC_DEF0, 2'd1, 2'd1, 32'h8ABC_DEF0, "R3 R4 seg7");
        glob_cfg = 32'h0000_0008;
        fast_req(32'h8000_0001, 2'd2, 2'd1, 32'h9000_0001, "R2 R3 seg8");
        fast_req(32'hFFFF_FFFF, 2'd3, 2'd1, 32'h0FFF_FFFF, "R2 R3 seg15");
    endtask

    task automatic t_page;
        glob_cfg = 32'h0000_000C; seg_map = 16'h8181;
        page_req(32'h3000_4000, 2'd0, 19'h12345, 3'b100, 1'b0, 1, 1'b0);
        page_req(32'h9ABC_FFFF, 2'd2, 19'h7FFFF, 3'b101, 1'b0, 0, 1'b0);
        page_req(32'h1000_2000, 2'd1, 19'h00001, 3'b110, 1'b1, 2, 1'b0);
        page_req(32'hA5A5_A5A5, 2'd3, 19'h2AAAA, 3'b111, 1'b0, 0, 1'b0);
    endtask

    task automatic t_ignore_busy;
        glob_cfg = 32'h0000_0004; seg_map = 16'h0001;
        page_req(32'h5555_6000, 2'd1, 19'h0ABCD, 3'b110, 1'b0, 3, 1'b1);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_segment();
        t_page();
        t_ignore_busy();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule